// File: doc/BRIEF.md
# Bit-serial fixed-mask dot product

The block adds up those elements of an N-element input vector that a Boolean mask selects, and it does so one bit per clock. The mask is fixed when the design is elaborated. A start pulse loads every selected element into its own shift register. Each register then streams its element out least significant bit first, with sign or zero extension past the element width. The streams meet in a registered binary tree of bit-serial adders, and the serial sum is assembled in an output shift register. A single-cycle done pulse marks the moment the complete word is available on the result port.

The mask is folded into the structure at elaboration. A lane whose mask bit is zero has no register and feeds a constant zero into the tree. A tree node that sees only one live operand shrinks to a plain delay flip-flop. A node with no live operand below it disappears. Adder cost therefore follows the number of set mask bits. The same hardware serves signed and unsigned elements, and the choice between them is a parameter.

Top module: `bsdot_top`

## Requirements
- R1: After each start, `result` equals the sum of the selected elements `in_vec[i*W +: W]`, where the selected elements are those with `MASK[i]` = 1. The sum is taken modulo 2^OW, with OW = W + clog2(N).
- R2: `done` is high for exactly one cycle, clog2(N) + OW cycles after the clock edge that sampled `start`.
- R3: The values of elements whose mask bit is 0 have no effect on `result`.
- R4: With `SIGNED` = 1, each element is read as two's complement, its most significant bit is repeated beyond W, and `result` is the two's-complement sum.
- R5: With `SIGNED` = 0, each element is read as unsigned and zero-extended beyond W. This holds for a mask with every bit set and for N not a power of two.
- R6: After `done`, `result` holds its value until the output register starts to fill again, clog2(N) + 1 cycles after the next start.
- R7: A start during a computation restarts it. Only the latest start produces a `done`, and its result uses the latest inputs. No `done` appears in the cycle after a start.
- R8: After reset, `result` is 0 and `done` is 0.
- R9: With an all-zero mask, `result` is 0 after every computation.
- R10: Carries from an earlier computation never reach a later one. Back-to-back computations each give the exact sum of their own inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Loads `in_vec` and begins a computation |
| in_vec | input | N*W | Packed elements, element i at bits i*W upward |
| result | output | W+clog2(N) | Serially assembled sum |
| done | output | 1 | One-cycle pulse: `result` is complete |

## Verification
A result is due clog2(N) + W + clog2(N) cycles after the edge that samples start. That comes to 12 cycles for the 8-lane signed instance, 10 for the 5-lane unsigned instance and 8 for the 4-lane all-zero instance. The bench counts falling edges from that sampling edge and records the cycle in which each instance first shows done. It checks that cycle against the computed latency, and it reads the result only in that cycle. After a run it waits several idle cycles and reads the result again to confirm that it held. For a restart it counts from the second start and checks that no done appears earlier.

// File: rtl/bsdot_pkg.sv
package bsdot_pkg;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // depth of heap node k (root k=1 has depth 0)
  function automatic int node_depth(input int k);
    int d;
    d = 0;
    while ((1 << (d + 1)) <= k) d++;
    return d;
  endfunction

  // any mask bit set among the leaves under heap node k of a tree with p leaves
  function automatic bit node_live(input logic [63:0] mask, input int k, input int p);
    int d;
    int span;
    int lo;
    bit any;
    d    = node_depth(k);
    span = p >> d;
    lo   = (k - (1 << d)) * span;
    any  = 1'b0;
    for (int i = 0; i < span; i++) begin
      if (lo + i < 64) any = any | mask[lo + i];
    end
    return any;
  endfunction

endpackage

// File: rtl/bsdot_lane.sv
module bsdot_lane #(
  parameter int W      = 6,
  parameter bit SIGNED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         bit_o
);
  logic [W-1:0] sr_q;
  logic         fill;

  assign fill  = SIGNED ? sr_q[W-1] : 1'b0;
  assign bit_o = sr_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n)    sr_q <= '0;
    else if (load) sr_q <= din;
    else           sr_q <= {fill, sr_q[W-1:1]};
  end
endmodule

// File: rtl/bsdot_node.sv
module bsdot_node
  import bsdot_pkg::*;
#(
  parameter bit A_LIVE = 1'b1,
  parameter bit B_LIVE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic a,
  input  logic b,
  output logic s
);
  logic unused_ok;
  assign unused_ok = ^{a, b, clr};

  if (A_LIVE && B_LIVE) begin : g_add
    logic sum_q;
    logic cy_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sum_q <= 1'b0;
        cy_q  <= 1'b0;
      end else begin
        sum_q <= fa_sum(a, b, cy_q);
        cy_q  <= clr ? 1'b0 : fa_carry(a, b, cy_q);
      end
    end
    assign s = sum_q;
  end else if (A_LIVE || B_LIVE) begin : g_dly
    logic d_q;
    always_ff @(posedge clk) begin
      if (!rst_n) d_q <= 1'b0;
      else        d_q <= A_LIVE ? a : b;
    end
    assign s = d_q;
  end else begin : g_none
    assign s = 1'b0;
  end
endmodule

// File: rtl/bsdot_ctrl.sv
module bsdot_ctrl #(
  parameter int LVL = 3,
  parameter int OW  = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic [LVL-1:0] clr,
  output logic           cap,
  output logic           run,
  output logic           done
);
  localparam int LAST = LVL + OW - 1;
  localparam int CW   = $clog2(LAST + 2);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          done_q;
  logic          last_w;

  assign last_w = run_q && (cnt_q == CW'(LAST));
  assign cap    = run_q && (cnt_q >= CW'(LVL));
  assign run    = run_q;
  assign done   = done_q;

  // level 1 clears its carries on the start edge, level l one edge per level later
  assign clr[0] = start;
  for (genvar l = 2; l <= LVL; l++) begin : g_clr
    assign clr[l-1] = run_q && (cnt_q == CW'(l - 2));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= !start && last_w;
      if (start) begin
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (last_w) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsdot_top.sv
module bsdot_top
  import bsdot_pkg::*;
#(
  parameter int           N      = 8,
  parameter int           W      = 6,
  parameter logic [N-1:0] MASK   = 8'b1011_0110,
  parameter bit           SIGNED = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [N*W-1:0]              in_vec,
  output logic [W+$clog2(N)-1:0]      result,
  output logic                        done
);
  localparam int          LVL    = $clog2(N);
  localparam int          P      = 1 << LVL;
  localparam int          OW     = W + LVL;
  localparam logic [63:0] MASK64 = 64'(MASK);

  logic [2*P-1:1] tree_w;
  logic [LVL-1:0] clr_w;
  logic           cap_w;
  logic           run_w;
  logic [OW-1:0]  out_q;
  logic           unused_in;

  assign unused_in = ^in_vec;

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N && MASK64[i]) begin : g_on
      bsdot_lane #(.W(W), .SIGNED(SIGNED)) lane_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .din   (in_vec[i*W +: W]),
        .bit_o (tree_w[P+i])
      );
    end else begin : g_off
      assign tree_w[P+i] = 1'b0;
    end
  end

  for (genvar k = 1; k < P; k++) begin : g_node
    bsdot_node #(
      .A_LIVE (node_live(MASK64, 2*k,     P)),
      .B_LIVE (node_live(MASK64, 2*k + 1, P))
    ) node_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_w[LVL - node_depth(k) - 1]),
      .a     (tree_w[2*k]),
      .b     (tree_w[2*k+1]),
      .s     (tree_w[k])
    );
  end

  bsdot_ctrl #(.LVL(LVL), .OW(OW)) ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .clr   (clr_w),
    .cap   (cap_w),
    .run   (run_w),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     out_q <= '0;
    else if (cap_w) out_q <= {tree_w[1], out_q[OW-1:1]};
  end

  assign result = out_q;
endmodule

// File: rtl/bsdot_chk.sv
module bsdot_chk #(
  parameter int LAT = 12,
  parameter int OW  = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic [OW-1:0] result,
  input logic          cap_w,
  input logic          run_w
);
  localparam int SW = $clog2(LAT + 3);

  logic [SW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      since_q <= '0;
    else if (start)                  since_q <= SW'(1);
    else if (since_q != SW'(LAT + 2)) since_q <= since_q + 1'b1;
  end

  // R2: done arrives exactly LAT cycles after the sampling edge of start
  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_q == SW'(LAT + 1)));

  // R2: done lasts one cycle
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a start is never followed directly by done
  assert_no_done_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  // R6: the result only moves on capture edges
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_w |=> $stable(result));

  // R1: the output is captured in the cycle before done, inside a run
  assert_capture_before_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cap_w) && $past(run_w)));
endmodule

bind bsdot_top bsdot_chk #(.LAT(LVL + OW), .OW(OW)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .done   (done),
  .result (result),
  .cap_w  (cap_w),
  .run_w  (run_w)
);

// File: tb/bsdot_tb_top.sv
module bsdot_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #10 clk = ~clk;

  localparam logic [7:0] MA = 8'b1011_0110;
  localparam logic [4:0] MU = 5'b11111;
  localparam logic [3:0] MZ = 4'b0000;

  logic [47:0] va;
  logic [19:0] vu;
  logic [15:0] vz;
  logic [8:0]  ra;
  logic [6:0]  ru;
  logic [5:0]  rz;
  logic        da, du, dz;

  bsdot_top #(.N(8), .W(6), .MASK(MA), .SIGNED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_vec(va), .result(ra), .done(da));
  bsdot_top #(.N(5), .W(4), .MASK(MU), .SIGNED(1'b0)) dut_u_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_vec(vu), .result(ru), .done(du));
  bsdot_top #(.N(4), .W(4), .MASK(MZ), .SIGNED(1'b1)) dut_z_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_vec(vz), .result(rz), .done(dz));

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  function automatic longint exp_sum(input logic [63:0] vec, input int n, input int w,
                                     input logic [63:0] mask, input bit sgn, input int ow);
    longint s;
    longint e;
    s = 0;
    for (int i = 0; i < n; i++) begin
      e = longint'((vec >> (i * w)) & ((64'd1 << w) - 1));
      if (sgn && e[w-1]) e = e - (longint'(1) << w);
      if (mask[i]) s = s + e;
    end
    return s & ((longint'(1) << ow) - 1);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int lat_a, lat_u, lat_z, n_a;
  logic [8:0] got_a;
  logic [6:0] got_u;
  logic [5:0] got_z;

  task automatic wait_done(input int first_c);
    lat_a = -1; lat_u = -1; lat_z = -1; n_a = 0;
    for (int c = first_c; c < 30; c++) begin
      @(negedge clk);
      if (c == 0) start = 1'b0;
      if (da) begin n_a++; if (lat_a < 0) begin lat_a = c; got_a = ra; end end
      if (du && lat_u < 0) begin lat_u = c; got_u = ru; end
      if (dz && lat_z < 0) begin lat_z = c; got_z = rz; end
    end
  endtask

  task automatic run3(input logic [47:0] a, input logic [19:0] u, input logic [15:0] z,
                      input string tag);
    @(negedge clk);
    va = a; vu = u; vz = z; start = 1'b1;
    wait_done(0);
    chk({tag, " R2 latency signed"}, lat_a, 12);
    chk({tag, " R2 single pulse"}, n_a, 1);
    chk({tag, " R2 latency unsigned"}, lat_u, 10);
    chk({tag, " R2 latency zero-mask"}, lat_z, 8);
    chk({tag, " R1 R4 signed sum"}, longint'(got_a), exp_sum(64'(a), 8, 6, 64'(MA), 1'b1, 9));
    chk({tag, " R5 unsigned sum"}, longint'(got_u), exp_sum(64'(u), 5, 4, 64'(MU), 1'b0, 7));
    chk({tag, " R9 zero mask"}, longint'(got_z), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        tests++;
        $display("[TB] FAIL watchdog expired actual=%0d expected=<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [47:0] a;
    logic [8:0]  held;
    void'($urandom(32'd2024));
    va = '0; vu = '0; vz = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk("R8 result after reset", longint'(ra), 0);
    chk("R8 done after reset", longint'(da), 0);
    chk("R8 unsigned result after reset", longint'(ru), 0);

    // directed corners: largest positive, most negative, all ones (R4, R5)
    run3({8{6'b011111}}, {5{4'hF}}, 16'hFFFF, "max");
    run3({8{6'b100000}}, {5{4'h0}}, 16'h8888, "minneg");
    run3({8{6'b111111}}, {5{4'h8}}, 16'h1234, "minus1");

    // R3: change only unmasked lanes (mask 0 at lanes 0,3,6), result must match
    a = {8{6'b010101}};
    run3(a, 20'h12345, 16'h0, "r3_base");
    held = got_a;
    a[0*6 +: 6] = 6'b100001; a[3*6 +: 6] = 6'b111000; a[6*6 +: 6] = 6'b011011;
    run3(a, 20'h12345, 16'h0, "r3_alt");
    chk("R3 unmasked lanes ignored", longint'(got_a), longint'(held));

    // R6: result holds while idle
    repeat (6) @(negedge clk);
    chk("R6 result held after done", longint'(ra), longint'(held));

    // R10 and random: back-to-back runs with random data
    for (int t = 0; t < 40; t++) begin
      run3({$urandom(), $urandom()}, 20'($urandom()), 16'($urandom()), "r10_rand");
    end

    // R7: restart three cycles into a run
    @(negedge clk);
    va = {8{6'b000111}}; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    a = {6'b101010, 6'b010011, 6'b111110, 6'b000001, 6'b100111, 6'b011000, 6'b110001, 6'b001101};
    va = a; start = 1'b1;
    wait_done(0);
    chk("R7 restart latency", lat_a, 12);
    chk("R7 restart single done", n_a, 1);
    chk("R7 restart uses latest inputs", longint'(got_a), exp_sum(64'(a), 8, 6, 64'(MA), 1'b1, 9));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule